// File: doc/BRIEF.md
# Video Event Interrupt Controller

This block watches the vertical sync and data-enable strobes of a video stream, plus a tearing-effect pulse that arrives from outside the clock domain. It turns six kinds of video event into interrupt requests. The events are the rise and fall of vertical sync, the rise and fall of data enable, the end of a frame, and the arrival of a tearing-effect pulse. Each event sets its own sticky status flag. One combined interrupt line goes high while any flagged event is also enabled.

Software reaches the block through one 32-bit control/status word. The low half holds the per-event enables. The high half holds the status flags, each 16 positions above its enable, and a flag is cleared by writing a 1 to it. End of frame is found by counting falling edges of data enable since the last rise of vertical sync, against a programmed number of active lines.

Top module: `vid_evt_irq`

## Requirements
- R1: After a synchronous reset the control/status word reads 0 and `irq` is 0.
- R2: A write stores `reg_wdata[5:0]` as the six enables at bits 5:0 of the word. Bits 31:22 and 15:6 always read 0, whatever value is written to them. Without a write, the enables keep their value.
- R3: Each event sets its status flag whether or not it is enabled. The flags are bit 16 tearing effect, bit 17 vsync rise, bit 18 vsync fall, bit 19 DE rise, bit 20 DE fall and bit 21 end of frame. A flag that is set stays set until it is cleared.
- R4: A write with a 1 in bit 16+i clears flag i, unless flag i is being set in the same cycle. A 0 in that bit leaves flag i unchanged. The same write also updates the enables.
- R5: When an event and a write-1 clear of the same flag happen in the same clock, the flag ends up set.
- R6: `irq` is registered. It equals the OR over i of (flag i AND enable i), using the values the word held one clock earlier.
- R7: An edge is detected by comparing a strobe with its own value one clock earlier. The matching flag is visible on `reg_rdata` after the clock edge at which the new strobe level is first sampled. A strobe held at one level yields a single event.
- R8: End of frame fires on the falling edge of DE that completes line number `cfg_lines` after the most recent vsync rise. Lines past that count do not fire it again until the next vsync rise. A `cfg_lines` value of 0 never fires it.
- R9: `te_in` passes through a two-flop synchronizer. A pulse that goes high sets flag 16 at the third clock edge after it goes high, not earlier. A pulse produces one event only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vs_in | input | 1 | Vertical sync strobe, active high, in the clock domain |
| de_in | input | 1 | Data-enable strobe, active high, in the clock domain |
| te_in | input | 1 | Asynchronous tearing-effect pulse, active high |
| cfg_lines | input | LINE_W (12) | Number of active lines per frame, used for end-of-frame detection |
| reg_wr | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 32 | Write data: bits 21:16 are clear-on-1 for the flags, bits 5:0 are the new enables |
| reg_rdata | output | 32 | Current control/status word |
| irq | output | 1 | Combined registered interrupt request |

## Verification
A vector table walks the strobes through held levels and single transitions, with the enables set in one pass and cleared in another. This shows that flags are set independently of the enables while `irq` follows only the enabled ones. The table also sends writes with clear bits to flags that are idle, to flags that are set, and to a flag that sets in the same cycle. These separate a true write-1-to-clear from a plain overwrite, and show which side wins the collision. Directed sequences then count DE pulses against several line counts, including zero and a restart at vsync, to tell an exact line match from an off-by-one. A tearing-effect pulse is sampled one edge before and at the edge it is expected to land, which pins the synchronizer depth.

// File: rtl/vei_pkg.sv
package vei_pkg;
  localparam int NUM_EVT  = 6;
  localparam int STAT_OFS = 16;
  localparam int REG_W    = 32;

  // Event slot numbers; a flag lives at STAT_OFS + slot
  localparam int EV_TE      = 0;
  localparam int EV_VS_RISE = 1;
  localparam int EV_VS_FALL = 2;
  localparam int EV_DE_RISE = 3;
  localparam int EV_DE_FALL = 4;
  localparam int EV_EOF     = 5;
endpackage

// File: rtl/vei_te_sync.sv
module vei_te_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/vei_edge.sv
module vei_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      assign rise[g] =  level[g] & ~level_q[g];
      assign fall[g] = ~level[g] &  level_q[g];
    end
  endgenerate
endmodule

// File: rtl/vei_eof.sv
module vei_eof #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              line_end,
  input  logic [LINE_W-1:0] cfg_lines,
  output logic              eof
);
  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W:0]   next_line;

  assign next_line = {1'b0, line_cnt} + {{LINE_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)                                line_cnt <= '0;
    else if (frame_start)                   line_cnt <= '0;
    else if (line_end && line_cnt != CNT_MAX) line_cnt <= next_line[LINE_W-1:0];
  end

  assign eof = line_end && !frame_start && (next_line == {1'b0, cfg_lines});
endmodule

// File: rtl/vei_regs.sv
module vei_regs #(
  parameter int NUM_EVT  = 6,
  parameter int STAT_OFS = 16,
  parameter int REG_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [NUM_EVT-1:0] wr_en_bits,
  input  logic [NUM_EVT-1:0] wr_clr_bits,
  input  logic [NUM_EVT-1:0] evt,
  output logic [REG_W-1:0]   rdata,
  output logic               irq
);
  localparam int HI_PAD = REG_W - STAT_OFS - NUM_EVT;
  localparam int LO_PAD = STAT_OFS - NUM_EVT;

  logic [NUM_EVT-1:0] stat_q;
  logic [NUM_EVT-1:0] en_q;
  logic               irq_q;

  genvar g;
  generate
    for (g = 0; g < NUM_EVT; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)                       stat_q[g] <= 1'b0;
        else if (evt[g])               stat_q[g] <= 1'b1;
        else if (wr && wr_clr_bits[g]) stat_q[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr) en_q <= wr_en_bits;
      irq_q <= |(stat_q & en_q);
    end
  end

  assign rdata = {{HI_PAD{1'b0}}, stat_q, {LO_PAD{1'b0}}, en_q};
  assign irq   = irq_q;
endmodule

// File: rtl/vid_evt_irq.sv
module vid_evt_irq
  import vei_pkg::*;
#(
  parameter int LINE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vs_in,
  input  logic              de_in,
  input  logic              te_in,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [1:0]         strobe_rise;
  logic [1:0]         strobe_fall;
  logic               te_rise;
  logic               eof_evt;
  logic [NUM_EVT-1:0] evt;
  logic               unused_wdata_bits;

  assign unused_wdata_bits = ^{reg_wdata[REG_W-1:STAT_OFS+NUM_EVT],
                               reg_wdata[STAT_OFS-1:NUM_EVT]};

  vei_te_sync #(.STAGES(SYNC_STAGES)) te_sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in (te_in),
    .rise     (te_rise)
  );

  // bit 0 = vsync, bit 1 = data enable
  vei_edge #(.W(2)) edge_i (
    .clk   (clk),
    .rst   (rst),
    .level ({de_in, vs_in}),
    .rise  (strobe_rise),
    .fall  (strobe_fall)
  );

  vei_eof #(.LINE_W(LINE_W)) eof_i (
    .clk         (clk),
    .rst         (rst),
    .frame_start (strobe_rise[0]),
    .line_end    (strobe_fall[1]),
    .cfg_lines   (cfg_lines),
    .eof         (eof_evt)
  );

  always_comb begin
    evt             = '0;
    evt[EV_TE]      = te_rise;
    evt[EV_VS_RISE] = strobe_rise[0];
    evt[EV_VS_FALL] = strobe_fall[0];
    evt[EV_DE_RISE] = strobe_rise[1];
    evt[EV_DE_FALL] = strobe_fall[1];
    evt[EV_EOF]     = eof_evt;
  end

  vei_regs #(.NUM_EVT(NUM_EVT), .STAT_OFS(STAT_OFS), .REG_W(REG_W)) regs_i (
    .clk         (clk),
    .rst         (rst),
    .wr          (reg_wr),
    .wr_en_bits  (reg_wdata[NUM_EVT-1:0]),
    .wr_clr_bits (reg_wdata[STAT_OFS +: NUM_EVT]),
    .evt         (evt),
    .rdata       (reg_rdata),
    .irq         (irq)
  );
endmodule

// File: rtl/vid_evt_irq_chk.sv
module vid_evt_irq_chk (
  input logic        clk,
  input logic        rst,
  input logic        vs_in,
  input logic        reg_wr,
  input logic [5:0]  wr_en_bits,
  input logic [5:0]  wr_clr_bits,
  input logic [31:0] reg_rdata,
  input logic        irq
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[31:22] == 10'd0 && reg_rdata[15:6] == 10'd0);

  // R2
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> reg_rdata[5:0] == $past(wr_en_bits));

  // R2
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> $stable(reg_rdata[5:0]));

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |($past(reg_rdata[21:16]) & $past(reg_rdata[5:0])));

  // R7
  vs_rise_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_in) |=> reg_rdata[17]);

  // R7
  vs_fall_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vs_in) |=> reg_rdata[18]);

  genvar g;
  generate
    for (g = 0; g < 6; g++) begin : g_sticky
      // R3
      flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[16+g] && !(reg_wr && wr_clr_bits[g])) |=> reg_rdata[16+g]);
    end
  endgenerate
endmodule

bind vid_evt_irq vid_evt_irq_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .vs_in       (vs_in),
  .reg_wr      (reg_wr),
  .wr_en_bits  (reg_wdata[5:0]),
  .wr_clr_bits (reg_wdata[21:16]),
  .reg_rdata   (reg_rdata),
  .irq         (irq)
);

// File: tb/vid_evt_irq_tb_top.sv
`timescale 1ns/1ps
module vid_evt_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vs_in = 1'b0;
  logic        de_in = 1'b0;
  logic        te_in = 1'b0;
  logic [11:0] cfg_lines = 12'd2;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vid_evt_irq dut_i (
    .clk(clk), .rst(rst), .vs_in(vs_in), .de_in(de_in), .te_in(te_in),
    .cfg_lines(cfg_lines), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // {wr, wdata, vs, de, expected word, expected irq}
  localparam int NVEC = 17;
  localparam logic [67:0] VEC [NVEC] = '{
    {1'b1, 32'h0000_003F, 1'b0, 1'b0, 32'h0000_003F, 1'b0}, // R2 enables on
    {1'b0, 32'h0,         1'b1, 1'b0, 32'h0002_003F, 1'b0}, // R7 vs rise
    {1'b0, 32'h0,         1'b1, 1'b0, 32'h0002_003F, 1'b1}, // R7 held, R6
    {1'b0, 32'h0,         1'b0, 1'b0, 32'h0006_003F, 1'b1}, // R7 vs fall
    {1'b1, 32'h0006_003F, 1'b0, 1'b0, 32'h0000_003F, 1'b1}, // R4 clear
    {1'b0, 32'h0,         1'b0, 1'b1, 32'h0008_003F, 1'b0}, // R7 de rise
    {1'b0, 32'h0,         1'b0, 1'b0, 32'h0018_003F, 1'b1}, // line 1 ends
    {1'b0, 32'h0,         1'b0, 1'b1, 32'h0018_003F, 1'b1},
    {1'b0, 32'h0,         1'b0, 1'b0, 32'h0038_003F, 1'b1}, // R8 eof line 2
    {1'b1, 32'h003F_0000, 1'b0, 1'b0, 32'h0000_0000, 1'b1}, // R4 clear all
    {1'b0, 32'h0,         1'b0, 1'b1, 32'h0008_0000, 1'b0}, // R3 disabled
    {1'b0, 32'h0,         1'b0, 1'b0, 32'h0018_0000, 1'b0}, // R8 no re-fire
    {1'b1, 32'hFFC0_FFC0, 1'b0, 1'b0, 32'h0018_0000, 1'b0}, // R2 reserved
    {1'b1, 32'h0008_0008, 1'b0, 1'b1, 32'h0018_0008, 1'b0}, // R5 set wins
    {1'b0, 32'h0,         1'b0, 1'b1, 32'h0018_0008, 1'b1}, // R6
    {1'b1, 32'h0018_0000, 1'b0, 1'b1, 32'h0000_0000, 1'b1}, // R4
    {1'b0, 32'h0,         1'b0, 1'b1, 32'h0000_0000, 1'b0}  // R6 drops
  };

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // drive at the falling edge, sample 2 ns after the following rising edge
  task automatic step(input logic wr, input logic [31:0] wd, input logic vs, input logic de);
    @(negedge clk);
    reg_wr = wr; reg_wdata = wd; vs_in = vs; de_in = de;
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 32'h0, vs_in, de_in);
  endtask

  task automatic line_pulse();
    step(1'b0, 32'h0, 1'b0, 1'b1);
    step(1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic frame_start();
    step(1'b0, 32'h0, 1'b1, 1'b0);
    step(1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic clear_all();
    step(1'b1, 32'h003F_0000, vs_in, de_in);
    step(1'b0, 32'h0, vs_in, de_in);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk32("R1 reset word", reg_rdata, 32'h0);
    chk1("R1 reset irq", irq, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][67], VEC[i][66:35], VEC[i][34], VEC[i][33]);
      chk32($sformatf("R2/R3/R4/R5/R7/R8 vector %0d word", i), reg_rdata, VEC[i][32:1]);
      chk1($sformatf("R6 vector %0d irq", i), irq, VEC[i][0]);
    end

    // R8: three lines per frame, restart at vsync
    step(1'b0, 32'h0, 1'b0, 1'b0);
    cfg_lines = 12'd3;
    frame_start();
    clear_all();
    line_pulse(); line_pulse();
    chk1("R8 no eof after line 2 of 3", reg_rdata[21], 1'b0);
    line_pulse();
    chk1("R8 eof after line 3 of 3", reg_rdata[21], 1'b1);
    clear_all();
    line_pulse();
    chk1("R8 no eof on line 4", reg_rdata[21], 1'b0);
    frame_start();
    line_pulse(); line_pulse();
    chk1("R8 restart: no eof at line 2", reg_rdata[21], 1'b0);
    line_pulse();
    chk1("R8 restart: eof at line 3", reg_rdata[21], 1'b1);

    // R8: zero line count never fires
    cfg_lines = 12'd0;
    frame_start();
    clear_all();
    for (int k = 0; k < 5; k++) line_pulse();
    chk1("R8 zero count no eof", reg_rdata[21], 1'b0);

    // R9: tearing-effect pulse through synchronizer
    clear_all();
    step(1'b1, 32'h0000_0001, 1'b0, 1'b0);
    @(negedge clk);
    te_in = 1'b1;
    @(posedge clk); #2;
    @(negedge clk);
    te_in = 1'b0;
    @(posedge clk); #2;
    chk1("R9 te not yet at edge 2", reg_rdata[16], 1'b0);
    @(posedge clk); #2;
    chk1("R9 te flag at edge 3", reg_rdata[16], 1'b1);
    step(1'b1, 32'h0001_0001, 1'b0, 1'b0);
    chk1("R4 te flag cleared", reg_rdata[16], 1'b0);
    idle(4);
    chk1("R9 single event per pulse", reg_rdata[16], 1'b0);
    chk1("R6 irq low after te cleared", irq, 1'b0);

    // R1: reset in mid-operation
    step(1'b1, 32'h0000_003F, 1'b1, 1'b1);
    idle(2);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #2;
    @(posedge clk); #2;
    chk32("R1 mid reset word", reg_rdata, 32'h0);
    chk1("R1 mid reset irq", irq, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule